// File: doc/BRIEF.md
# Servo Loop Sequencer with Limit Check

This block closes a position or force loop between a 16-bit converter sample stream and a 16-bit valve-drive output. A feedback channel, either displacement or load, is smoothed by a first-order recursive low-pass filter on a fast tick. The smoothed value is compared with an upper and a lower bound. On a slow tick, a PID controller acts on the set point minus the last in-range feedback value. The controller result is slew-limited before it reaches the converter.

Any bound violation latches a fault. While the fault is set, the valve sees a programmed safe code and the integrator holds its value. The host clears the fault once the feedback is back inside the bounds. Set point, bounds, safe code and process value are all expressed in signed converter counts. Both tick periods are parameters: `FAST_DIV` clock cycles make one fast tick, and `SLOW_DIV` fast ticks make one slow tick.

Top module: `servo_seq`

## Requirements
- R1: After reset, `dac_o`, `pv_o`, `hi_flag_o`, `lo_flag_o` and `fault_o` are all zero.
- R2: `src_sel_i` = 0 feeds the filter from `disp_adc_i`; `src_sel_i` = 1 feeds it from `load_adc_i`.
- R3: On each fast tick the filtered value y becomes y + ((x - y) >>> k), where k = `filt_shift_i`. With k = 0, y equals the input after one tick. With k > 0, a step from below settles within 2^k - 1 counts under the input.
- R4: `hi_flag_o` is 1 exactly when `pv_o` > `lim_hi_i`. `lo_flag_o` is 1 exactly when `pv_o` < `lim_lo_i`. A value equal to a bound raises no flag.
- R5: A raised flag sets `fault_o` on the next clock, and the fault stays set. `fault_clr_i` clears it only in a cycle where both flags are 0.
- R6: While `fault_o` is 1, `dac_o` equals `safe_val_i`. After the fault clears, the output slews from the safe code.
- R7: While `fault_o` is 1, the integrator holds its value, and the controller uses the last filtered value that was inside the bounds.
- R8: On each slow tick, with e = setpoint - pv, the integrator I += (ki*e) >>> FRAC, and the output u = ((kp*e + kd*(e - e_prev)) >>> FRAC) + I. Gains are signed with FRAC fraction bits, so 256 means unity when FRAC = 8.
- R9: The integrator and u are each saturated to the range -32768 to 32767.
- R10: Anti-windup: if u saturated on the previous slow tick, integration is skipped on this one.
- R11: Per slow tick, `dac_o` moves toward u by at most `step_i` (unsigned), and by exactly `step_i` while farther away than that.
- R12: Fast ticks come every `FAST_DIV` clocks and slow ticks every `SLOW_DIV` fast ticks. Outside a fault, `dac_o` changes at most once per slow period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_adc_i | input | 16 | Displacement sample, signed |
| load_adc_i | input | 16 | Load sample, signed |
| src_sel_i | input | 1 | Feedback select: 0 displacement, 1 load |
| filt_shift_i | input | 3 | Filter shift k |
| lim_hi_i | input | 16 | Upper bound, signed |
| lim_lo_i | input | 16 | Lower bound, signed |
| setpoint_i | input | 16 | Set point, signed |
| kp_i | input | 16 | Proportional gain, signed fixed point |
| ki_i | input | 16 | Integral gain, signed fixed point |
| kd_i | input | 16 | Derivative gain, signed fixed point |
| step_i | input | 16 | Maximum output change per slow tick, unsigned |
| safe_val_i | input | 16 | Output code forced during a fault, signed |
| fault_clr_i | input | 1 | Fault clear request |
| dac_o | output | 16 | Valve-drive code, signed |
| pv_o | output | 16 | Filtered process value, signed |
| hi_flag_o | output | 1 | Upper bound exceeded |
| lo_flag_o | output | 1 | Lower bound undercut |
| fault_o | output | 1 | Sticky limit fault |

## Verification
The assertions assume that `lim_lo_i` never exceeds `lim_hi_i`. They also assume that `step_i` is the value the slew limiter used on the tick before a change is judged. The stimulus keeps the bounds fixed at ±30000 and changes `step_i` only between slow ticks. The stimulus then waits at least one full slow period before judging any slew step. Feedback values are driven well away from the bounds, except where a test deliberately sits exactly on a bound or one count outside it.

// File: rtl/servo_pkg.sv
package servo_pkg;
  localparam int DATA_W  = 16;
  localparam int SHIFT_W = 3;
  localparam int FRAC_W  = 8;

  typedef enum logic {SRC_DISP = 1'b0, SRC_LOAD = 1'b1} src_e;
endpackage

// File: rtl/servo_tick.sv
module servo_tick #(
  parameter int FAST_DIV = 2500,
  parameter int SLOW_DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic fast_o,
  output logic slow_o
);
  localparam int FW = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
  localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [FW-1:0] f_q;
  logic [SW-1:0] s_q;

  assign fast_o = (f_q == FW'(FAST_DIV - 1));
  assign slow_o = fast_o && (s_q == SW'(SLOW_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_q <= '0;
      s_q <= '0;
    end else begin
      f_q <= fast_o ? '0 : f_q + 1'b1;
      if (fast_o) s_q <= slow_o ? '0 : s_q + 1'b1;
    end
  end
endmodule

// File: rtl/servo_lim_filter.sv
module servo_lim_filter #(
  parameter int DW = servo_pkg::DATA_W,
  parameter int KW = servo_pkg::SHIFT_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic signed [DW-1:0] x_i,
  input  logic        [KW-1:0] shift_i,
  input  logic signed [DW-1:0] hi_lim_i,
  input  logic signed [DW-1:0] lo_lim_i,
  input  logic                 clr_i,
  output logic signed [DW-1:0] y_o,
  output logic                 hi_o,
  output logic                 lo_o,
  output logic                 fault_o,
  output logic signed [DW-1:0] pv_ok_o
);
  localparam int EW = DW + 1;

  logic signed [DW-1:0] y_q, ok_q;
  logic signed [EW-1:0] diff, incr;
  logic                 fault_q;

  assign diff = EW'(x_i) - EW'(y_q);
  assign incr = diff >>> shift_i;
  assign hi_o = (y_q > hi_lim_i);
  assign lo_o = (y_q < lo_lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q     <= '0;
      ok_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      if (tick_i) y_q <= DW'(EW'(y_q) + incr);
      if (!hi_o && !lo_o) ok_q <= y_q;  // gate: only in-range values reach the loop
      if (hi_o || lo_o)   fault_q <= 1'b1;
      else if (clr_i)     fault_q <= 1'b0;
    end
  end

  assign y_o     = y_q;
  assign pv_ok_o = ok_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/servo_pid.sv
module servo_pid #(
  parameter int DW   = servo_pkg::DATA_W,
  parameter int FRAC = servo_pkg::FRAC_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 freeze_i,
  input  logic signed [DW-1:0] sp_i,
  input  logic signed [DW-1:0] pv_i,
  input  logic signed [DW-1:0] kp_i,
  input  logic signed [DW-1:0] ki_i,
  input  logic signed [DW-1:0] kd_i,
  output logic signed [DW-1:0] u_o,
  output logic                 vld_o
);
  localparam int EW = DW + 1;
  localparam int PW = 2 * DW + 3;
  localparam int SW = PW + 2;
  localparam logic signed [SW-1:0] MAXV = (SW'(1) <<< (DW - 1)) - SW'(1);
  localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);

  logic signed [EW-1:0] err, err_q;
  logic signed [PW-1:0] p_prod, i_prod, d_prod, pd_sum;
  logic signed [SW-1:0] i_sum, u_sum;
  logic signed [DW-1:0] i_q, i_nx, u_q;
  logic                 sat_q, u_sat, int_en;

  function automatic logic signed [DW-1:0] clip(input logic signed [SW-1:0] v);
    if (v > MAXV)      return DW'(MAXV);
    else if (v < MINV) return DW'(MINV);
    else               return DW'(v);
  endfunction

  assign err    = EW'(sp_i) - EW'(pv_i);
  assign p_prod = PW'(kp_i) * PW'(err);
  assign i_prod = PW'(ki_i) * PW'(err);
  assign d_prod = PW'(kd_i) * (PW'(err) - PW'(err_q));
  assign pd_sum = p_prod + d_prod;

  assign int_en = !freeze_i && !sat_q;  // anti-windup and fault hold
  assign i_sum  = SW'(i_q) + SW'(i_prod >>> FRAC);
  assign i_nx   = int_en ? clip(i_sum) : i_q;
  assign u_sum  = SW'(i_nx) + SW'(pd_sum >>> FRAC);
  assign u_sat  = (u_sum > MAXV) || (u_sum < MINV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= '0;
      i_q   <= '0;
      u_q   <= '0;
      sat_q <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= tick_i;
      if (tick_i) begin
        err_q <= err;
        i_q   <= i_nx;
        u_q   <= clip(u_sum);
        sat_q <= u_sat;
      end
    end
  end

  assign u_o = u_q;
endmodule

// File: rtl/servo_slew.sv
module servo_slew #(
  parameter int DW = servo_pkg::DATA_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic                 fault_i,
  input  logic signed [DW-1:0] u_i,
  input  logic        [DW-1:0] step_i,
  input  logic signed [DW-1:0] safe_i,
  output logic signed [DW-1:0] dac_o
);
  localparam int XW = DW + 2;

  logic signed [DW-1:0] q;
  logic signed [XW-1:0] delta, lim, clamp;

  assign delta = XW'(u_i) - XW'(q);
  assign lim   = {2'b00, step_i};
  assign clamp = (delta > lim) ? lim : ((delta < -lim) ? -lim : delta);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (fault_i) q <= safe_i;  // restart slewing from the safe code
    else if (vld_i)   q <= DW'(XW'(q) + clamp);
  end

  assign dac_o = fault_i ? safe_i : q;
endmodule

// File: rtl/servo_seq.sv
module servo_seq #(
  parameter int DW       = servo_pkg::DATA_W,
  parameter int KW       = servo_pkg::SHIFT_W,
  parameter int FRAC     = servo_pkg::FRAC_W,
  parameter int FAST_DIV = 2500,
  parameter int SLOW_DIV = 50
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] disp_adc_i,
  input  logic signed [DW-1:0] load_adc_i,
  input  logic                 src_sel_i,
  input  logic        [KW-1:0] filt_shift_i,
  input  logic signed [DW-1:0] lim_hi_i,
  input  logic signed [DW-1:0] lim_lo_i,
  input  logic signed [DW-1:0] setpoint_i,
  input  logic signed [DW-1:0] kp_i,
  input  logic signed [DW-1:0] ki_i,
  input  logic signed [DW-1:0] kd_i,
  input  logic        [DW-1:0] step_i,
  input  logic signed [DW-1:0] safe_val_i,
  input  logic                 fault_clr_i,
  output logic signed [DW-1:0] dac_o,
  output logic signed [DW-1:0] pv_o,
  output logic                 hi_flag_o,
  output logic                 lo_flag_o,
  output logic                 fault_o
);
  logic                 fast_tick, slow_tick, pid_vld;
  logic signed [DW-1:0] fb_sel, pv_ok, pid_u;

  assign fb_sel = (servo_pkg::src_e'(src_sel_i) == servo_pkg::SRC_LOAD) ? load_adc_i : disp_adc_i;

  servo_tick #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_tick (
    .clk_i (clk_i), .rst_ni(rst_ni), .fast_o(fast_tick), .slow_o(slow_tick)
  );

  servo_lim_filter #(.DW(DW), .KW(KW)) u_filt (
    .clk_i   (clk_i),      .rst_ni  (rst_ni),    .tick_i (fast_tick),
    .x_i     (fb_sel),     .shift_i (filt_shift_i),
    .hi_lim_i(lim_hi_i),   .lo_lim_i(lim_lo_i),  .clr_i  (fault_clr_i),
    .y_o     (pv_o),       .hi_o    (hi_flag_o), .lo_o   (lo_flag_o),
    .fault_o (fault_o),    .pv_ok_o (pv_ok)
  );

  servo_pid #(.DW(DW), .FRAC(FRAC)) u_pid (
    .clk_i (clk_i),      .rst_ni  (rst_ni), .tick_i(slow_tick), .freeze_i(fault_o),
    .sp_i  (setpoint_i), .pv_i    (pv_ok),
    .kp_i  (kp_i),       .ki_i    (ki_i),   .kd_i  (kd_i),
    .u_o   (pid_u),      .vld_o   (pid_vld)
  );

  servo_slew #(.DW(DW)) u_slew (
    .clk_i (clk_i),  .rst_ni(rst_ni), .vld_i (pid_vld), .fault_i(fault_o),
    .u_i   (pid_u),  .step_i(step_i), .safe_i(safe_val_i), .dac_o(dac_o)
  );
endmodule

// File: rtl/servo_seq_chk.sv
module servo_seq_chk #(
  parameter int DW = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic signed [DW-1:0] dac_o,
  input logic        [DW-1:0] step_i,
  input logic signed [DW-1:0] safe_val_i,
  input logic                 fault_clr_i,
  input logic                 hi_flag_o,
  input logic                 lo_flag_o,
  input logic                 fault_o
);
  logic signed [DW-1:0] dac_prev;
  logic        [DW-1:0] step_prev;
  logic                 fault_prev;
  logic signed [DW:0]   move;
  logic        [DW:0]   move_abs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_prev   <= '0;
      step_prev  <= '0;
      fault_prev <= 1'b1;
    end else begin
      dac_prev   <= dac_o;
      step_prev  <= step_i;
      fault_prev <= fault_o;
    end
  end

  assign move     = (DW+1)'(dac_o) - (DW+1)'(dac_prev);
  assign move_abs = move[DW] ? (DW+1)'(-move) : (DW+1)'(move);

  // R11: slew bound on every output change outside a fault
  p_slew_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_o && !fault_prev) |-> (move_abs <= {1'b0, step_prev}));

  // R5: violation latches the fault
  p_flag_sets_fault_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_flag_o || lo_flag_o) |=> fault_o);

  // R5: fault stays until a clear request
  p_fault_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fault_o) && !$past(fault_clr_i)) |-> fault_o);

  // R4: both flags never at once while bounds are ordered
  p_flags_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_flag_o && lo_flag_o));

  // R6: entering a fault the output shows the safe code
  p_safe_on_fault_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> (dac_o == safe_val_i));
endmodule

bind servo_seq servo_seq_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dac_o      (dac_o),
  .step_i     (step_i),
  .safe_val_i (safe_val_i),
  .fault_clr_i(fault_clr_i),
  .hi_flag_o  (hi_flag_o),
  .lo_flag_o  (lo_flag_o),
  .fault_o    (fault_o)
);

// File: tb/servo_seq_bench.sv
module servo_seq_bench;
  localparam int DW = 16;
  localparam int PER = 16;  // clocks per slow tick with FAST_DIV=4, SLOW_DIV=4

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic signed [DW-1:0] disp_adc, load_adc, lim_hi, lim_lo, setpoint, kp, ki, kd, safe_val;
  logic [DW-1:0] step;
  logic [2:0] shift;
  logic src_sel, fault_clr;
  logic signed [DW-1:0] dac, pv;
  logic hi_flag, lo_flag, fault;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;  // 125 MHz

  servo_seq #(.FAST_DIV(4), .SLOW_DIV(4)) u_servo_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .disp_adc_i(disp_adc), .load_adc_i(load_adc), .src_sel_i(src_sel), .filt_shift_i(shift),
    .lim_hi_i(lim_hi), .lim_lo_i(lim_lo), .setpoint_i(setpoint),
    .kp_i(kp), .ki_i(ki), .kd_i(kd), .step_i(step), .safe_val_i(safe_val),
    .fault_clr_i(fault_clr),
    .dac_o(dac), .pv_o(pv), .hi_flag_o(hi_flag), .lo_flag_o(lo_flag), .fault_o(fault)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 dac", int'(dac), 0);
    chk("R1 pv", int'(pv), 0);
    chk("R1 flags", int'({hi_flag, lo_flag, fault}), 0);
  endtask

  task automatic t_source;
    load_adc = 16'sd1234; src_sel = 1'b1; cyc(12);
    chk("R2 load channel", int'(pv), 1234);
    src_sel = 1'b0; disp_adc = -16'sd777; cyc(12);
    chk("R2 displacement channel", int'(pv), -777);
  endtask

  task automatic t_filter;
    disp_adc = 16'sd0; cyc(12);
    shift = 3'd3; disp_adc = 16'sd800; cyc(6);
    chk("R3 partial step", int'(pv > 0 && pv < 800), 1);
    cyc(300);
    chk("R3 settled", int'(pv >= 793 && pv <= 800), 1);
    shift = 3'd0; cyc(12);
    chk("R3 k=0 follows", int'(pv), 800);
  endtask

  task automatic t_bounds;
    disp_adc = 16'sd30000; cyc(12);
    chk("R4 on upper bound", int'({hi_flag, fault}), 0);
    disp_adc = -16'sd30000; cyc(12);
    chk("R4 on lower bound", int'({lo_flag, fault}), 0);
    disp_adc = -16'sd30001; cyc(12);
    chk("R4 lo flag", int'({hi_flag, lo_flag}), 1);
    chk("R5 fault set", int'(fault), 1);
    chk("R6 safe code", int'(dac), -1000);
    disp_adc = 16'sd0; cyc(12);
    chk("R5 sticky", int'({lo_flag, fault}), 1);
    fault_clr = 1'b1; cyc(1); fault_clr = 1'b0; cyc(2);
    chk("R5 cleared", int'(fault), 0);
  endtask

  task automatic t_prop;
    disp_adc = 16'sd400; cyc(12);
    setpoint = 16'sd1000; kp = 16'sd256; cyc(4 * PER);
    chk("R8 proportional +", int'(dac), 600);
    setpoint = -16'sd2000; cyc(4 * PER);
    chk("R8 proportional -", int'(dac), -2400);
  endtask

  task automatic t_slew;
    int a;
    step = 16'd50; setpoint = 16'sd400; cyc(40);
    a = int'(dac);
    cyc(PER);
    chk("R11 exact step", int'(dac) - a, 50);
    chk("R12 one move per slow period", int'((int'(dac) + 2400) % 50), 0);
    cyc(60 * PER);
    chk("R11 reaches target", int'(dac), 0);
    step = 16'hFFFF;
  endtask

  task automatic t_deriv;
    int mx = -100000;
    kp = 16'sd0; kd = 16'sd256; cyc(3 * PER);
    chk("R8 derivative idle", int'(dac), 0);
    setpoint = 16'sd700;
    for (int i = 0; i < 3 * PER; i++) begin
      cyc(1);
      if (int'(dac) > mx) mx = int'(dac);
    end
    chk("R8 derivative spike", mx, 300);
    chk("R8 derivative decays", int'(dac), 0);
    kd = 16'sd0;
  endtask

  task automatic t_windup;
    disp_adc = 16'sd0; setpoint = 16'sd0; cyc(3 * PER);
    setpoint = 16'sd20000; kp = 16'sd256; ki = 16'sd256; cyc(6 * PER);
    chk("R9 output saturated", int'(dac), 32767);
    setpoint = 16'sd0; cyc(6 * PER);
    chk("R10 integrator held", int'(dac), 20000);
  endtask

  task automatic t_freeze;
    kp = 16'sd0;
    disp_adc = 16'sd31000; cyc(12);
    chk("R4 hi flag", int'({hi_flag, lo_flag}), 2);
    chk("R6 safe code", int'(dac), -1000);
    fault_clr = 1'b1; cyc(1); fault_clr = 1'b0; cyc(2);
    chk("R5 clear ignored out of range", int'(fault), 1);
    setpoint = 16'sd500; cyc(12 * PER);
    chk("R6 safe held", int'(dac), -1000);
    ki = 16'sd0; disp_adc = 16'sd0; cyc(12);
    fault_clr = 1'b1; cyc(1); fault_clr = 1'b0; cyc(4 * PER);
    chk("R7 integrator frozen", int'(dac), 20000);
  endtask

  initial begin
    disp_adc = '0; load_adc = '0; src_sel = 1'b0; shift = 3'd0;
    lim_hi = 16'sd30000; lim_lo = -16'sd30000; setpoint = '0;
    kp = '0; ki = '0; kd = '0; step = 16'hFFFF; safe_val = -16'sd1000; fault_clr = 1'b0;
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    t_reset();
    t_source();
    t_filter();
    t_bounds();
    t_prop();
    t_slew();
    t_deriv();
    t_windup();
    t_freeze();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule